// File: doc/BRIEF.md
# Flash Write-Protection Controller

This block decides, one decoded command at a time, whether a write-type operation on a serial flash may go ahead. The serial front end hands it a command kind with its address and data. Separately, the front end signals the end of each chip-select frame. The block answers every command with a one-cycle grant or deny pulse. It owns the write-enable latch and the two protection fields of the status register: a pin-enable bit and a two-bit region selector. It also runs the self-timed internal cycle of a status-register write and shows that cycle on a busy output.

Program and erase requests are refused when the latch is clear or when the address falls in the protected region. The region is chosen by the selector: none, top quarter, top half or whole array. A build option reduces the selector to whole-array only, for the smaller array.

A status write is held pending until its frame ends. During that window a low write-protect pin cancels it, provided the pin-enable bit is set. Once the internal cycle has started, the pin no longer affects it.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset, grant, deny and busy are 0 and statusOut reads 0x00: latch clear, pin-enable 0, region field 00.
- R2: Outside a pending or busy status write, command code 1 sets the write-enable latch and code 2 clears it. Each answers with a grant pulse one cycle after the command.
- R3: A program (code 4) or erase (code 5) request while the latch is clear is answered with deny, and the latch stays clear.
- R4: Region field 00 protects nothing. 01 protects addresses whose two top bits are 11. 10 protects addresses whose top bit is 1. 11 protects every address. A program or erase request with the latch set is answered with deny inside the region and with grant outside it.
- R5: A granted program or erase clears the latch in the same cycle as the grant. A denied one leaves the latch unchanged.
- R6: A status write (code 3) accepted with the latch set produces no pulse until the frame-end strobe. One cycle after that strobe, grant pulses and busy rises. Busy stays high for exactly WRITE_CYCLES cycles. In the cycle it falls, status bits 7 and 3:2 take cmdData bits 7 and 3:2, and the latch clears.
- R7: When pin-enable is 1 and wpN is low as a status write arrives, that write is denied at once and the status register is unchanged.
- R8: When pin-enable is 0, wpN has no effect on accepting or completing a status write.
- R9: When pin-enable is 1 and wpN is sampled low while a status write is pending (before its frame-end strobe), the write is cancelled. Deny pulses the next cycle, busy stays low, and the status register and latch are unchanged.
- R10: A low wpN during the internal status write cycle does not change its outcome, and status bits 7:2 stay constant while busy is high.
- R11: Any command that arrives while a status write is pending or busy is answered with deny and changes nothing. Grant and deny are never high together.
- R12: statusOut is {pin-enable, 000, region[1:0], latch, busy}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wpN | input | 1 | Write-protect pin, active low |
| cmdValid | input | 1 | One-cycle strobe: a decoded command is present |
| cmdKind | input | 3 | 0 none, 1 set latch, 2 clear latch, 3 status write, 4 program, 5 erase |
| cmdAddr | input | ADDR_W | Target byte address for program or erase |
| cmdData | input | 8 | New status value for a status write |
| frameEnd | input | 1 | One-cycle strobe at the chip-select rising edge |
| grant | output | 1 | One-cycle pulse: operation allowed |
| deny | output | 1 | One-cycle pulse: operation refused or cancelled |
| busy | output | 1 | Internal status write cycle in progress |
| statusOut | output | 8 | Status register image |

## Verification
The hardest state to reach from the ports is the narrow window between an accepted status write and its frame-end strobe. The pin only cancels the write inside that window, and only after an earlier status write has set pin-enable. The stimulus therefore first raises pin-enable while the pin is held low, which proves the pin is ignored while disabled. It then parks a status write in the pending state and drops the pin before sending the frame end. A second write then drops the pin only after the cycle has started, along with a command issued mid-cycle, to show the difference between the two cases.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_SETWE = 3'd1,
    CMD_CLRWE = 3'd2,
    CMD_WRST  = 3'd3,
    CMD_PROG  = 3'd4,
    CMD_ERASE = 3'd5
  } cmd_e;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic capture;
    logic commit;
    logic grant;
    logic deny;
  } strobe_t;

  localparam int STATUS_W   = 8;
  localparam int PIN_EN_BIT = 7;
  localparam int REGION_HI  = 3;
  localparam int REGION_LO  = 2;

endpackage

// File: rtl/wprot_datapath.sv
module wprot_datapath
  import wprot_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter bit FULL_MAP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  output logic              wel,
  output logic              pinEn,
  output logic [1:0]        region,
  output logic              inRegion,
  output logic              grantQ,
  output logic              denyQ
);

  logic       captPinEn;
  logic [1:0] captRegion;

  // Region decode; the variant is picked at build time.
  generate
    if (FULL_MAP) begin : g_fullMap
      always_comb begin
        case (region)
          2'b00:   inRegion = 1'b0;
          2'b01:   inRegion = &cmdAddr[ADDR_W-1 -: 2];
          2'b10:   inRegion = cmdAddr[ADDR_W-1];
          default: inRegion = 1'b1;
        endcase
      end
    end else begin : g_wholeOnly
      always_comb inRegion = |region;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wel <= 1'b0;
    end else if (st.clrWel || st.commit) begin
      wel <= 1'b0;
    end else if (st.setWel) begin
      wel <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      captPinEn  <= 1'b0;
      captRegion <= 2'b00;
    end else if (st.capture) begin
      captPinEn  <= cmdData[PIN_EN_BIT];
      captRegion <= cmdData[REGION_HI:REGION_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinEn  <= 1'b0;
      region <= 2'b00;
    end else if (st.commit) begin
      pinEn  <= captPinEn;
      region <= captRegion;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ <= 1'b0;
      denyQ  <= 1'b0;
    end else begin
      grantQ <= st.grant;
      denyQ  <= st.deny;
    end
  end

endmodule

// File: rtl/wprot_control.sv
module wprot_control
  import wprot_pkg::*;
#(
  parameter int WRITE_CYCLES = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  cmd_e    cmdKind,
  input  logic    frameEnd,
  input  logic    wpN,
  input  logic    wel,
  input  logic    pinEn,
  input  logic    inRegion,
  output strobe_t st,
  output logic    busy,
  output logic    armed
);

  localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_ARMED, PH_BUSY} phase_e;

  phase_e          phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic            pinLock;

  assign pinLock = pinEn && !wpN;
  assign busy    = (phase == PH_BUSY);
  assign armed   = (phase == PH_ARMED);

  always_comb begin
    st        = '0;
    phaseNext = phase;
    cntNext   = cnt;
    case (phase)
      PH_IDLE: begin
        if (cmdValid) begin
          case (cmdKind)
            CMD_SETWE: begin
              st.setWel = 1'b1;
              st.grant  = 1'b1;
            end
            CMD_CLRWE: begin
              st.clrWel = 1'b1;
              st.grant  = 1'b1;
            end
            CMD_PROG, CMD_ERASE: begin
              if (wel && !inRegion) begin
                st.clrWel = 1'b1;
                st.grant  = 1'b1;
              end else begin
                st.deny = 1'b1;
              end
            end
            CMD_WRST: begin
              if (wel && !pinLock) begin
                st.capture = 1'b1;
                phaseNext  = PH_ARMED;
              end else begin
                st.deny = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      PH_ARMED: begin
        if (pinLock) begin
          st.deny   = 1'b1;
          phaseNext = PH_IDLE;
        end else if (frameEnd) begin
          st.grant  = 1'b1;
          phaseNext = PH_BUSY;
          cntNext   = CNT_LOAD;
        end else if (cmdValid) begin
          st.deny = 1'b1;
        end
      end
      PH_BUSY: begin
        if (cmdValid) begin
          st.deny = 1'b1;
        end
        if (cnt == '0) begin
          st.commit = 1'b1;
          phaseNext = PH_IDLE;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phaseNext;
      cnt   <= cntNext;
    end
  end

  // A cancelled pending write never enters the internal cycle.
  AST_ABORT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (armed && pinEn && !wpN) |=> !busy); // R9

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int WRITE_CYCLES = 8,
  parameter bit FULL_MAP     = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdKind,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              frameEnd,
  output logic              grant,
  output logic              deny,
  output logic              busy,
  output logic [7:0]        statusOut
);

  strobe_t    st;
  logic       wel, pinEn, inRegion, armed;
  logic [1:0] region;
  cmd_e       kind;

  assign kind = cmd_e'(cmdKind);

  wprot_control #(.WRITE_CYCLES(WRITE_CYCLES)) u_control (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(kind),
    .frameEnd(frameEnd), .wpN(wpN), .wel(wel), .pinEn(pinEn),
    .inRegion(inRegion), .st(st), .busy(busy), .armed(armed)
  );

  wprot_datapath #(.ADDR_W(ADDR_W), .FULL_MAP(FULL_MAP)) u_datapath (
    .clk(clk), .rstN(rstN), .st(st), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .wel(wel), .pinEn(pinEn), .region(region), .inRegion(inRegion),
    .grantQ(grant), .denyQ(deny)
  );

  assign statusOut = {pinEn, 3'b000, region, wel, busy};

  logic isPgEr;
  assign isPgEr = cmdValid && (kind == CMD_PROG || kind == CMD_ERASE) && !armed && !busy;

  AST_NO_GRANT_WITHOUT_WEL: assert property (@(posedge clk) disable iff (!rstN)
    (isPgEr && !wel) |=> !grant); // R3

  AST_REGION_DENIES: assert property (@(posedge clk) disable iff (!rstN)
    (isPgEr && inRegion) |=> (deny && !grant)); // R4

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(grant && deny)); // R11

  AST_CYCLE_END_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel); // R6

  AST_STATUS_HELD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(statusOut[7:2])); // R10

endmodule

// File: tb/test_wprot_ctrl.sv
`timescale 1ns/1ps
module test_wprot_ctrl;

  localparam int AW = 17;
  localparam int WC = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wpN = 1'b1;
  logic          cmdValid = 1'b0;
  logic [2:0]    cmdKind = 3'd0;
  logic [AW-1:0] cmdAddr = '0;
  logic [7:0]    cmdData = 8'h00;
  logic          frameEnd = 1'b0;
  logic          grant, deny, busy;
  logic [7:0]    statusOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wprot_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WC), .FULL_MAP(1'b1)) i_wprot_ctrl (
    .clk(clk), .rstN(rstN), .wpN(wpN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .frameEnd(frameEnd),
    .grant(grant), .deny(deny), .busy(busy), .statusOut(statusOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: 0 idle, 1 pending, 2 running
  int mMode = 0, mLeft = 0;
  bit mWel = 0, mPin = 0, mGrant = 0, mDeny = 0, mNewPin = 0;
  int mReg = 0, mNewReg = 0;

  function automatic bit hit(int addr, int sel);
    if (sel == 3) return 1;
    if (sel == 2) return addr >= 'h10000;
    if (sel == 1) return addr >= 'h18000;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mLeft = 0; mWel = 0; mPin = 0; mReg = 0;
      mGrant = 0; mDeny = 0;
    end else begin
      mGrant = 0; mDeny = 0;
      if (mMode == 0) begin
        if (cmdValid) begin
          if (cmdKind == 1) begin mWel = 1; mGrant = 1; end
          else if (cmdKind == 2) begin mWel = 0; mGrant = 1; end
          else if (cmdKind == 4 || cmdKind == 5) begin
            if (mWel && !hit(int'(cmdAddr), mReg)) begin mWel = 0; mGrant = 1; end
            else mDeny = 1;
          end else if (cmdKind == 3) begin
            if (mWel && !(mPin && !wpN)) begin
              mNewPin = cmdData[7]; mNewReg = int'(cmdData[3:2]); mMode = 1;
            end else mDeny = 1;
          end
        end
      end else if (mMode == 1) begin
        if (mPin && !wpN) begin mDeny = 1; mMode = 0; end
        else if (frameEnd) begin mGrant = 1; mMode = 2; mLeft = WC; end
        else if (cmdValid) mDeny = 1;
      end else begin
        if (cmdValid) mDeny = 1;
        mLeft--;
        if (mLeft == 0) begin
          mMode = 0; mPin = mNewPin; mReg = mNewReg; mWel = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check("R11 grant vs model", int'(grant), int'(mGrant));
      check("R11 deny vs model", int'(deny), int'(mDeny));
      check("R6 busy vs model", int'(busy), int'(mMode == 2));
      check("R12 status vs model", int'(statusOut),
            (int'(mPin) << 7) | (mReg << 2) | (int'(mWel) << 1) | int'(mMode == 2));
    end
  end

  task automatic issue(input logic [2:0] k, input int a, input logic [7:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdKind = k; cmdAddr = AW'(a); cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0; cmdKind = 3'd0;
  endtask

  task automatic endFrame();
    @(negedge clk);
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 4 * WC && busy; i++) @(negedge clk);
  endtask

  task automatic writeStatus(input logic [7:0] v);
    issue(3'd1, 0, 8'h00);
    issue(3'd3, 0, v);
    endFrame();
    waitIdle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 status after reset", int'(statusOut), 'h00);
    check("R1 grant after reset", int'(grant), 0);
    check("R1 deny after reset", int'(deny), 0);
    check("R1 busy after reset", int'(busy), 0);
    rstN = 1'b1;

    issue(3'd4, 0, 8'h00);
    check("R3 program without latch", int'(deny), 1);
    issue(3'd5, 'h100, 8'h00);
    check("R3 erase without latch", int'(deny), 1);

    issue(3'd1, 0, 8'h00);
    check("R2 set latch grant", int'(grant), 1);
    check("R2 latch set", int'(statusOut[1]), 1);
    issue(3'd2, 0, 8'h00);
    check("R2 clear latch grant", int'(grant), 1);
    check("R2 latch clear", int'(statusOut[1]), 0);

    issue(3'd1, 0, 8'h00);
    issue(3'd4, 0, 8'h00);
    check("R5 program granted", int'(grant), 1);
    check("R5 latch cleared by grant", int'(statusOut[1]), 0);

    // status write to region 01
    issue(3'd1, 0, 8'h00);
    issue(3'd3, 0, 8'h04);
    check("R6 no pulse while pending", int'(grant | deny), 0);
    endFrame();
    check("R6 grant at frame end", int'(grant), 1);
    check("R6 busy raised", int'(busy), 1);
    for (int i = 1; i < WC; i++) @(negedge clk);
    check("R6 busy still high last cycle", int'(busy), 1);
    @(negedge clk);
    check("R6 busy low after cycle", int'(busy), 0);
    check("R6 status committed", int'(statusOut), 'h04);

    issue(3'd1, 0, 8'h00);
    issue(3'd4, 'h18000, 8'h00);
    check("R4 top quarter protected", int'(deny), 1);
    check("R5 latch kept on deny", int'(statusOut[1]), 1);
    issue(3'd4, 'h17FFF, 8'h00);
    check("R4 below quarter allowed", int'(grant), 1);

    writeStatus(8'h08);
    issue(3'd1, 0, 8'h00);
    issue(3'd5, 'h10000, 8'h00);
    check("R4 top half protected", int'(deny), 1);
    issue(3'd5, 'h0FFFF, 8'h00);
    check("R4 lower half allowed", int'(grant), 1);

    writeStatus(8'h0C);
    issue(3'd1, 0, 8'h00);
    issue(3'd4, 0, 8'h00);
    check("R4 whole array protected", int'(deny), 1);

    // pin ignored while pin-enable is 0
    wpN = 1'b0;
    writeStatus(8'h80);
    check("R8 write with pin low and enable 0", int'(statusOut), 'h80);

    issue(3'd1, 0, 8'h00);
    issue(3'd3, 0, 8'h0C);
    check("R7 pin lock denies", int'(deny), 1);
    check("R7 status unchanged", int'(statusOut), 'h82);

    wpN = 1'b1;
    issue(3'd3, 0, 8'h0C);
    check("R9 pending accepted", int'(grant | deny), 0);
    @(negedge clk);
    wpN = 1'b0;
    @(negedge clk);
    check("R9 cancel deny", int'(deny), 1);
    endFrame();
    check("R9 no cycle after cancel", int'(busy), 0);
    check("R9 status and latch kept", int'(statusOut), 'h82);

    wpN = 1'b1;
    issue(3'd3, 0, 8'h88);
    endFrame();
    wpN = 1'b0;
    issue(3'd1, 0, 8'h00);
    check("R11 command during cycle denied", int'(deny), 1);
    waitIdle();
    check("R10 late pin fall ignored", int'(statusOut), 'h88);
    wpN = 1'b1;

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule